// File: doc/BRIEF.md
# Serial Link Command Arbiter with Null Fill

This block feeds the transmit buffer of a serial link to an external converter device. The device holds two command buffers. Several command queues compete for the link. Each queue presents a head command, the external buffer that command targets, and whether the command is bound for an external buffer at all.

Whenever the link is enabled and ready for a new frame, the arbiter writes exactly one word into the transmit buffer. The word is one of two things:
- the head command of the highest-priority eligible queue, with that queue popped in the same cycle;
- a null message, which pops nothing.

A queue is eligible when it is triggered, not empty, its head command targets an external buffer, and that buffer is not full. The full status of each external buffer is kept in registers. It is refreshed from the busy fields of every result frame that comes back from the device. Because a queue aimed at a full buffer is passed over, a lower-priority queue can use the link, and the link never stalls for lack of a word.

Top module: `link_cmd_arb`

## Requirements
- R1: A transmit write (`tx_wr` high for one cycle) happens on the cycle after, and only after, a clock edge at which both `link_en` and `link_rdy` are high. Each such edge yields exactly one write, so consecutive ready cycles give consecutive writes.
- R2: Queue 0 has the highest priority and priority falls with the queue index. Among eligible queues the lowest index wins, and its head command appears on `tx_word`.
- R3: A queue whose target buffer is marked full is skipped. A lower-priority queue aimed at a buffer that is not full is sent instead.
- R4: A null message is written when no triggered queue has a head command with `q_head_ext` high.
- R5: A null message is written when queues with external commands are triggered but every buffer they target is full.
- R6: A queue that is triggered but empty is never chosen and does not block lower-priority queues.
- R7: The busy field of buffer b is `rslt_busy[2b+1:2b]`, and code 2'b11 means full. `buf_full` is loaded from these fields on each cycle with `rslt_vld` high. It holds its value at all other times.
- R8: A null message shows as `tx_wr=1`, `tx_null=1` and `tx_word=0`, with `q_pop` all zero.
- R9: `q_pop` is one-hot with the winning queue's bit during a command write, and all zero in every other cycle.
- R10: After reset, `tx_wr`, `tx_null` and `q_pop` are zero and no buffer is marked full.
- R11: A queue whose `q_trig` bit is low is never chosen.
- R12: A higher-priority queue that becomes eligible takes the next frame from a lower-priority queue that was sending frame after frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| link_en | input | 1 | Serial link enabled |
| link_rdy | input | 1 | Link ready to start a new frame |
| q_trig | input | NUM_Q | Per-queue trigger |
| q_empty | input | NUM_Q | Per-queue empty flag |
| q_head_ext | input | NUM_Q | Head command is bound for an external buffer |
| q_head_buf | input | NUM_Q*BIDX_W | Target external buffer index of each head command |
| q_head_cmd | input | NUM_Q*CMD_W | Head command of each queue |
| rslt_vld | input | 1 | Result frame received this cycle |
| rslt_busy | input | NUM_BUF*2 | Busy fields of the received result frame |
| tx_wr | output | 1 | Transmit buffer write strobe |
| tx_null | output | 1 | Word written is a null message |
| tx_word | output | CMD_W | Word written to the transmit buffer |
| q_pop | output | NUM_Q | One-hot pop of the queue whose command was written |
| buf_full | output | NUM_BUF | Full status per external buffer |

## Verification
The bench builds the block with four queues, two external buffers and 16-bit commands. With four queues, a single frame can pass over two blocked queues before it reaches a sendable one. The queues can also be split across both buffers so that one full buffer removes some candidates but not others. Two buffers with 2-bit busy fields make every pairing of full and not-full status reachable, including the case where all targets are full and the block falls back to null frames.

// File: rtl/link_cmd_arb_pkg.sv
package link_cmd_arb_pkg;
    localparam int BUSY_W    = 2;
    localparam logic [BUSY_W-1:0] BUSY_FULL = 2'b11;

    typedef enum logic [1:0] {
        ARB_IDLE = 2'd0,
        ARB_CMD  = 2'd1,
        ARB_NULL = 2'd2
    } arb_kind_e;

    function automatic logic busy_is_full(input logic [BUSY_W-1:0] code);
        return code == BUSY_FULL;
    endfunction
endpackage

// File: rtl/ext_busy_track.sv
module ext_busy_track
    import link_cmd_arb_pkg::*;
#(
    parameter int NUM_BUF = 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      rslt_vld,
    input  logic [NUM_BUF*BUSY_W-1:0] rslt_busy,
    output logic [NUM_BUF-1:0]        full_q
);
    logic [NUM_BUF-1:0] full_d;

    for (genvar b = 0; b < NUM_BUF; b++) begin : g_dec
        assign full_d[b] = busy_is_full(rslt_busy[b*BUSY_W +: BUSY_W]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            full_q <= '0;
        end else if (rslt_vld) begin
            full_q <= full_d;
        end
    end
endmodule

// File: rtl/queue_elig.sv
module queue_elig #(
    parameter int NUM_Q   = 4,
    parameter int NUM_BUF = 2,
    parameter int BIDX_W  = 1
) (
    input  logic [NUM_Q-1:0]        q_trig,
    input  logic [NUM_Q-1:0]        q_empty,
    input  logic [NUM_Q-1:0]        q_head_ext,
    input  logic [NUM_Q*BIDX_W-1:0] q_head_buf,
    input  logic [NUM_BUF-1:0]      buf_full,
    output logic [NUM_Q-1:0]        elig
);
    for (genvar i = 0; i < NUM_Q; i++) begin : g_q
        logic [BIDX_W-1:0] tgt;
        logic              tgt_open;
        assign tgt = q_head_buf[i*BIDX_W +: BIDX_W];
        always_comb begin
            tgt_open = 1'b0;
            for (int b = 0; b < NUM_BUF; b++) begin
                if (tgt == BIDX_W'(b)) tgt_open = !buf_full[b];
            end
        end
        assign elig[i] = q_trig[i] && !q_empty[i] && q_head_ext[i] && tgt_open;
    end
endmodule

// File: rtl/prio_first.sv
module prio_first #(
    parameter int N     = 4,
    parameter int IDX_W = 2
) (
    input  logic [N-1:0]     req,
    output logic [N-1:0]     grant,
    output logic [IDX_W-1:0] idx,
    output logic             found
);
    always_comb begin
        grant = '0;
        idx   = '0;
        found = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && !found) begin
                grant[i] = 1'b1;
                idx      = IDX_W'(i);
                found    = 1'b1;
            end
        end
    end
endmodule

// File: rtl/link_cmd_arb.sv
module link_cmd_arb
    import link_cmd_arb_pkg::*;
#(
    parameter int NUM_Q   = 4,
    parameter int NUM_BUF = 2,
    parameter int CMD_W   = 16,
    localparam int BIDX_W = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1,
    localparam int QIDX_W = (NUM_Q > 1) ? $clog2(NUM_Q) : 1
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      link_en,
    input  logic                      link_rdy,
    input  logic [NUM_Q-1:0]          q_trig,
    input  logic [NUM_Q-1:0]          q_empty,
    input  logic [NUM_Q-1:0]          q_head_ext,
    input  logic [NUM_Q*BIDX_W-1:0]   q_head_buf,
    input  logic [NUM_Q*CMD_W-1:0]    q_head_cmd,
    input  logic                      rslt_vld,
    input  logic [NUM_BUF*BUSY_W-1:0] rslt_busy,
    output logic                      tx_wr,
    output logic                      tx_null,
    output logic [CMD_W-1:0]          tx_word,
    output logic [NUM_Q-1:0]          q_pop,
    output logic [NUM_BUF-1:0]        buf_full
);
    logic [NUM_Q-1:0]  elig;
    logic [NUM_Q-1:0]  grant;
    logic [QIDX_W-1:0] win_idx;
    logic              win_found;
    arb_kind_e         kind;

    ext_busy_track #(.NUM_BUF(NUM_BUF)) busy_i (
        .clk       (clk),
        .rst       (rst),
        .rslt_vld  (rslt_vld),
        .rslt_busy (rslt_busy),
        .full_q    (buf_full)
    );

    queue_elig #(.NUM_Q(NUM_Q), .NUM_BUF(NUM_BUF), .BIDX_W(BIDX_W)) elig_i (
        .q_trig     (q_trig),
        .q_empty    (q_empty),
        .q_head_ext (q_head_ext),
        .q_head_buf (q_head_buf),
        .buf_full   (buf_full),
        .elig       (elig)
    );

    prio_first #(.N(NUM_Q), .IDX_W(QIDX_W)) pick_i (
        .req   (elig),
        .grant (grant),
        .idx   (win_idx),
        .found (win_found)
    );

    always_comb begin
        if (!(link_en && link_rdy)) kind = ARB_IDLE;
        else if (win_found)         kind = ARB_CMD;
        else                        kind = ARB_NULL;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_wr   <= 1'b0;
            tx_null <= 1'b0;
            tx_word <= '0;
            q_pop   <= '0;
        end else begin
            case (kind)
                ARB_CMD: begin
                    tx_wr   <= 1'b1;
                    tx_null <= 1'b0;
                    tx_word <= q_head_cmd[win_idx*CMD_W +: CMD_W];
                    q_pop   <= grant;
                end
                ARB_NULL: begin
                    tx_wr   <= 1'b1;
                    tx_null <= 1'b1;
                    tx_word <= '0;
                    q_pop   <= '0;
                end
                default: begin
                    tx_wr   <= 1'b0;
                    tx_null <= 1'b0;
                    q_pop   <= '0;
                end
            endcase
        end
    end
endmodule

// File: rtl/link_cmd_arb_chk.sv
module link_cmd_arb_chk #(
    parameter int NUM_Q   = 4,
    parameter int NUM_BUF = 2,
    parameter int CMD_W   = 16
) (
    input logic               clk,
    input logic               rst,
    input logic               link_en,
    input logic               link_rdy,
    input logic [NUM_Q-1:0]   q_trig,
    input logic [NUM_Q-1:0]   q_empty,
    input logic [NUM_Q-1:0]   q_head_ext,
    input logic               rslt_vld,
    input logic               tx_wr,
    input logic               tx_null,
    input logic [CMD_W-1:0]   tx_word,
    input logic [NUM_Q-1:0]   q_pop,
    input logic [NUM_BUF-1:0] buf_full
);
    AST_WR_AFTER_READY: assert property (@(posedge clk) disable iff (rst)
        tx_wr |-> $past(link_en && link_rdy)) else $error("R1");  // R1
    AST_READY_GIVES_WR: assert property (@(posedge clk) disable iff (rst)
        (link_en && link_rdy) |=> tx_wr) else $error("R1");  // R1
    AST_NULL_SHAPE: assert property (@(posedge clk) disable iff (rst)
        tx_null |-> (tx_wr && tx_word == '0 && q_pop == '0)) else $error("R8");  // R8
    AST_POP_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(q_pop)) else $error("R9");  // R9
    AST_POP_WITH_CMD: assert property (@(posedge clk) disable iff (rst)
        (q_pop != '0) |-> (tx_wr && !tx_null)) else $error("R9");  // R9
    AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !$past(rslt_vld) |-> $stable(buf_full)) else $error("R7");  // R7

    for (genvar i = 0; i < NUM_Q; i++) begin : g_pop
        AST_POP_NEEDS_LIVE_Q: assert property (@(posedge clk) disable iff (rst)
            q_pop[i] |-> $past(q_trig[i] && !q_empty[i] && q_head_ext[i]))
            else $error("R6 R11");  // R6 R11
    end
endmodule

bind link_cmd_arb link_cmd_arb_chk #(.NUM_Q(NUM_Q), .NUM_BUF(NUM_BUF), .CMD_W(CMD_W)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .link_en    (link_en),
    .link_rdy   (link_rdy),
    .q_trig     (q_trig),
    .q_empty    (q_empty),
    .q_head_ext (q_head_ext),
    .rslt_vld   (rslt_vld),
    .tx_wr      (tx_wr),
    .tx_null    (tx_null),
    .tx_word    (tx_word),
    .q_pop      (q_pop),
    .buf_full   (buf_full)
);

// File: tb/link_cmd_arb_tb_top.sv
module link_cmd_arb_tb_top;
    localparam int NQ = 4;
    localparam int NB = 2;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          link_en = 1'b0;
    logic          link_rdy = 1'b0;
    logic [NQ-1:0] q_trig = '0;
    logic [NQ-1:0] q_empty = '0;
    logic [NQ-1:0] q_head_ext = '0;
    logic [NQ-1:0] q_head_buf = '0;
    logic [NQ*CW-1:0] q_head_cmd;
    logic          rslt_vld = 1'b0;
    logic [NB*2-1:0] rslt_busy = '0;
    logic          tx_wr, tx_null;
    logic [CW-1:0] tx_word;
    logic [NQ-1:0] q_pop;
    logic [NB-1:0] buf_full;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    for (genvar i = 0; i < NQ; i++) begin : g_cmd
        assign q_head_cmd[i*CW +: CW] = CW'(16'hA000 + i);
    end

    link_cmd_arb #(.NUM_Q(NQ), .NUM_BUF(NB), .CMD_W(CW)) dut_i (
        .clk(clk), .rst(rst), .link_en(link_en), .link_rdy(link_rdy),
        .q_trig(q_trig), .q_empty(q_empty), .q_head_ext(q_head_ext),
        .q_head_buf(q_head_buf), .q_head_cmd(q_head_cmd),
        .rslt_vld(rslt_vld), .rslt_busy(rslt_busy),
        .tx_wr(tx_wr), .tx_null(tx_null), .tx_word(tx_word),
        .q_pop(q_pop), .buf_full(buf_full)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // one ready cycle, then sample the registered result
    task automatic frame();
        link_en = 1'b1; link_rdy = 1'b1;
        @(posedge clk); #1;
        link_en = 1'b0; link_rdy = 1'b0;
        @(negedge clk);
    endtask

    task automatic expect_cmd(input string req, input int q);
        chk(req, "tx_wr", 32'(tx_wr), 32'd1);
        chk(req, "tx_null", 32'(tx_null), 32'd0);
        chk(req, "tx_word", 32'(tx_word), 32'(16'hA000 + q));
        chk(req, "q_pop", 32'(q_pop), 32'(1 << q));
    endtask

    task automatic expect_null(input string req);
        chk(req, "tx_wr", 32'(tx_wr), 32'd1);
        chk(req, "tx_null", 32'(tx_null), 32'd1);
        chk(req, "tx_word", 32'(tx_word), 32'd0);
        chk(req, "q_pop", 32'(q_pop), 32'd0);
    endtask

    task automatic result(input logic [3:0] busy);
        rslt_busy = busy; rslt_vld = 1'b1;
        @(posedge clk); #1;
        rslt_vld = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R10", "tx_wr", 32'(tx_wr), 32'd0);
        chk("R10", "tx_null", 32'(tx_null), 32'd0);
        chk("R10", "q_pop", 32'(q_pop), 32'd0);
        chk("R10", "buf_full", 32'(buf_full), 32'd0);
    endtask

    task automatic t_gating();
        q_trig = 4'hF; q_head_ext = 4'hF;
        link_en = 1'b1; link_rdy = 1'b0;
        @(posedge clk); #1; @(negedge clk);
        chk("R1", "no write when not ready", 32'(tx_wr), 32'd0);
        link_en = 1'b0; link_rdy = 1'b1;
        @(posedge clk); #1; @(negedge clk);
        chk("R1", "no write when disabled", 32'(tx_wr), 32'd0);
        link_rdy = 1'b0;
        @(negedge clk);
        chk("R9", "q_pop idle", 32'(q_pop), 32'd0);
    endtask

    task automatic t_priority();
        q_trig = 4'hF; q_empty = '0; q_head_ext = 4'hF; q_head_buf = 4'b1010;
        frame(); expect_cmd("R2", 0);
        @(negedge clk);
        chk("R9", "pop one cycle", 32'(q_pop), 32'd0);
        chk("R1", "strobe one cycle", 32'(tx_wr), 32'd0);
        q_trig = 4'b1110;
        frame(); expect_cmd("R11", 1);
        q_trig = 4'hF; q_empty = 4'b0011;
        frame(); expect_cmd("R6", 2);
        q_empty = '0;
    endtask

    task automatic t_full_skip();
        q_trig = 4'hF; q_head_ext = 4'hF; q_head_buf = 4'b1100;
        result(4'b0011);
        chk("R7", "buf0 full", 32'(buf_full), 32'b01);
        frame(); expect_cmd("R3", 2);
        rslt_busy = 4'b1111;
        @(negedge clk);
        chk("R7", "hold without valid", 32'(buf_full), 32'b01);
        result(4'b1111);
        chk("R7", "both full", 32'(buf_full), 32'b11);
        frame(); expect_null("R5");
        result(4'b0110);
        chk("R7", "codes 01 and 10 not full", 32'(buf_full), 32'b00);
        frame(); expect_cmd("R3", 0);
    endtask

    task automatic t_no_ext();
        q_trig = 4'hF; q_head_ext = '0;
        frame(); expect_null("R4");
        q_trig = '0; q_head_ext = 4'hF;
        frame(); expect_null("R4");
    endtask

    task automatic t_preempt();
        q_trig = 4'b1000; q_head_ext = 4'hF; q_head_buf = 4'b0000;
        link_en = 1'b1; link_rdy = 1'b1;
        @(posedge clk); #1;
        @(negedge clk); expect_cmd("R1", 3);
        q_trig = 4'b1010;
        @(posedge clk); #1;
        link_en = 1'b0; link_rdy = 1'b0;
        @(negedge clk); expect_cmd("R12", 1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_gating();
        t_priority();
        t_full_skip();
        t_no_ext();
        t_preempt();
        repeat (2) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            done = 1;
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule